// File: doc/BRIEF.md
# Sub-Page Write Permission Checker

This block decides whether a guest write to a guest physical address may go ahead when fine-grained write protection is active. A 4KB page is split into 32 regions of 128 bytes. Each region has one write-permission bit in a 64-bit vector. The permission bits sit at the even positions of the vector, and the odd positions must be zero. The block takes in the execution-control enable, the leaf translation entry and the write address. When a walk is needed, it also takes the vector that an external table walker returns.

Most writes are settled from the leaf entry alone. The checker involves the walker only when the leaf entry carries the sub-page flag (bit 61) and its own write bit (bit 1) is clear. In that case it raises a request to the walker and holds it until the walker grants. It then produces exactly one verdict: allowed, violation, or walker fault. A walker fault also reports whether it was a miss or a misconfiguration. The block does not walk tables, translate addresses or deliver exits.

Top module: `subpage_wr_guard`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, all four verdict outputs and `walk_req` are 0.
- R2: If `ctrl_en` is 0 or leaf bit 61 is 0, a request is decided from leaf bit 1 without a walk. The cycle after the request, `dec_allow` equals bit 1 and `dec_viol` equals its inverse.
- R3: If `ctrl_en` is 1 and leaf bits 61 and 1 are both set, `dec_allow` pulses the cycle after the request and no walk is requested.
- R4: If `ctrl_en` is 1, leaf bit 61 is set and leaf bit 1 is clear, `walk_req` rises the cycle after the request. It stays high up to and including the cycle in which `walk_gnt` is 1, and falls in the following cycle. While it is high, `walk_page` carries address bits [47:12] of the request.
- R5: The sub-page index i is address bits [11:7]. Its permission bit is bit 2i of `walk_vec`.
- R6: On a clean grant, the cycle after `walk_gnt` gives `dec_allow` if the selected bit is 1 and `dec_viol` if it is 0.
- R7: On a grant without walker fault, any set odd bit of `walk_vec` gives `dec_fault` with `dec_fault_miss` = 0.
- R8: A grant with `walk_misconf` = 1 gives `dec_fault` with `dec_fault_miss` = 0, even if `walk_miss` is also 1. A grant with only `walk_miss` = 1 gives `dec_fault` with `dec_fault_miss` = 1. In neither case does `dec_allow` or `dec_viol` rise.
- R9: At most one of `dec_allow`, `dec_viol` and `dec_fault` is high in any cycle. Each request produces one single-cycle verdict.
- R10: A `req_valid` that arrives while `walk_req` is high is ignored. It produces no verdict, and `walk_page` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en | input | 1 | Execution-control enable for sub-page checking |
| req_valid | input | 1 | Write request, valid for one cycle |
| req_addr | input | 48 | Guest physical write address |
| req_leaf | input | 64 | Leaf translation entry (bit 1 write, bit 61 sub-page flag) |
| walk_req | output | 1 | Request to the walker for the permission vector |
| walk_page | output | 36 | Page number the walker must look up |
| walk_gnt | input | 1 | Walker reply valid |
| walk_vec | input | 64 | Interleaved permission vector |
| walk_miss | input | 1 | Walker found a non-present entry |
| walk_misconf | input | 1 | Walker found a malformed entry |
| dec_allow | output | 1 | Write allowed, one-cycle pulse |
| dec_viol | output | 1 | Write denied as a translation violation, one-cycle pulse |
| dec_fault | output | 1 | Walker fault passed through, one-cycle pulse |
| dec_fault_miss | output | 1 | Fault kind: 1 miss, 0 misconfiguration |

## Verification
Requests that are settled from the leaf entry give their verdict in the first cycle after the clock edge that sampled `req_valid`. A walked request raises `walk_req` one cycle after that edge. Its verdict appears one cycle after the edge that samples `walk_gnt`, and `walk_req` is low in that same cycle. The bench's reference model advances on the rising edge from the inputs it saw there, and it compares every output on the falling edge that follows. Every expected value is therefore checked in the exact cycle it is due, never earlier or later.

// File: rtl/subpage_pkg.sv
package subpage_pkg;

    localparam int LEAF_W = 64;
    localparam int SP_BIT = 61;
    localparam int WR_BIT = 1;

    typedef enum logic {
        ST_IDLE,
        ST_WALK
    } guard_st_e;

    typedef enum logic [1:0] {
        RT_LEAF,
        RT_PASS,
        RT_WALK
    } route_e;

    typedef struct packed {
        logic allow;
        logic viol;
        logic fault;
        logic miss;
    } verdict_t;

    function automatic verdict_t verdict_none();
        verdict_t v;
        v = '0;
        return v;
    endfunction

    function automatic verdict_t verdict_fault(input logic is_miss);
        verdict_t v;
        v = '0;
        v.fault = 1'b1;
        v.miss  = is_miss;
        return v;
    endfunction

endpackage

// File: rtl/sp_route.sv
module sp_route
    import subpage_pkg::*;
(
    input  logic   ctrl_en,
    input  logic   leaf_sp,
    input  logic   leaf_wr,
    output route_e route
);
    always_comb begin
        if (!(ctrl_en && leaf_sp)) begin
            route = RT_LEAF;
        end else if (leaf_wr) begin
            route = RT_PASS;
        end else begin
            route = RT_WALK;
        end
    end
endmodule

// File: rtl/sp_vec_eval.sv
module sp_vec_eval
    import subpage_pkg::*;
#(
    parameter int NSUB  = 32,
    localparam int IDX_W = $clog2(NSUB),
    localparam int VEC_W = 2 * NSUB
) (
    input  logic [VEC_W-1:0] vec,
    input  logic [IDX_W-1:0] idx,
    input  logic             miss,
    input  logic             misconf,
    output verdict_t         verdict
);
    logic [NSUB-1:0] perm;
    logic [NSUB-1:0] rsv;

    for (genvar k = 0; k < NSUB; k++) begin : g_split
        assign perm[k] = vec[2*k];
        assign rsv[k]  = vec[2*k+1];
    end

    always_comb begin
        verdict = verdict_none();
        if (misconf) begin
            verdict = verdict_fault(1'b0);
        end else if (miss) begin
            verdict = verdict_fault(1'b1);
        end else if (|rsv) begin
            verdict = verdict_fault(1'b0);
        end else if (perm[idx]) begin
            verdict.allow = 1'b1;
        end else begin
            verdict.viol = 1'b1;
        end
    end
endmodule

// File: rtl/subpage_wr_guard.sv
module subpage_wr_guard
    import subpage_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int SUB_SHIFT  = 7,
    localparam int IDX_W  = PAGE_SHIFT - SUB_SHIFT,
    localparam int NSUB   = 1 << IDX_W,
    localparam int VEC_W  = 2 * NSUB,
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEAF_W-1:0] req_leaf,
    output logic              walk_req,
    output logic [PAGE_W-1:0] walk_page,
    input  logic              walk_gnt,
    input  logic [VEC_W-1:0]  walk_vec,
    input  logic              walk_miss,
    input  logic              walk_misconf,
    output logic              dec_allow,
    output logic              dec_viol,
    output logic              dec_fault,
    output logic              dec_fault_miss
);
    guard_st_e        st_q, st_d;
    verdict_t         out_q, out_d;
    verdict_t         walk_v;
    route_e           route;
    logic [IDX_W-1:0] idx_q;
    logic [PAGE_W-1:0] page_q;
    logic             accept_walk;
    logic             unused_leaf_bits;

    assign unused_leaf_bits = ^{req_leaf, req_addr[SUB_SHIFT-1:0]};

    sp_route u_route (
        .ctrl_en (ctrl_en),
        .leaf_sp (req_leaf[SP_BIT]),
        .leaf_wr (req_leaf[WR_BIT]),
        .route   (route)
    );

    sp_vec_eval #(.NSUB(NSUB)) u_eval (
        .vec     (walk_vec),
        .idx     (idx_q),
        .miss    (walk_miss),
        .misconf (walk_misconf),
        .verdict (walk_v)
    );

    assign accept_walk = (st_q == ST_IDLE) && req_valid && (route == RT_WALK);

    always_comb begin
        st_d  = st_q;
        out_d = verdict_none();
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    case (route)
                        RT_LEAF: begin
                            out_d.allow = req_leaf[WR_BIT];
                            out_d.viol  = !req_leaf[WR_BIT];
                        end
                        RT_PASS: out_d.allow = 1'b1;
                        default: st_d = ST_WALK;
                    endcase
                end
            end
            default: begin
                if (walk_gnt) begin
                    out_d = walk_v;
                    st_d  = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            out_q  <= verdict_none();
            idx_q  <= '0;
            page_q <= '0;
        end else begin
            st_q  <= st_d;
            out_q <= out_d;
            if (accept_walk) begin
                idx_q  <= req_addr[PAGE_SHIFT-1:SUB_SHIFT];
                page_q <= req_addr[ADDR_W-1:PAGE_SHIFT];
            end
        end
    end

    assign walk_req       = (st_q == ST_WALK);
    assign walk_page      = page_q;
    assign dec_allow      = out_q.allow;
    assign dec_viol       = out_q.viol;
    assign dec_fault      = out_q.fault;
    assign dec_fault_miss = out_q.miss;

endmodule

// File: rtl/subpage_wr_guard_chk.sv
module subpage_wr_guard_chk
    import subpage_pkg::*;
#(
    parameter int VEC_W  = 64,
    parameter int PAGE_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              ctrl_en,
    input logic              req_valid,
    input logic              leaf_sp,
    input logic              leaf_wr,
    input logic              walk_req,
    input logic [PAGE_W-1:0] walk_page,
    input logic              walk_gnt,
    input logic [VEC_W-1:0]  walk_vec,
    input logic              walk_miss,
    input logic              walk_misconf,
    input logic              dec_allow,
    input logic              dec_viol,
    input logic              dec_fault,
    input logic              dec_fault_miss
);
    logic odd_set;
    always_comb begin
        odd_set = 1'b0;
        for (int k = 1; k < VEC_W; k += 2) odd_set = odd_set | walk_vec[k];
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dec_allow, dec_viol, dec_fault})); // R9

    AST_BYPASS_LEAF: assert property (@(posedge clk) disable iff (rst)
        req_valid && !walk_req && !(ctrl_en && leaf_sp)
        |=> dec_allow == $past(leaf_wr) && dec_viol != $past(leaf_wr)); // R2

    AST_WRITABLE_PASS: assert property (@(posedge clk) disable iff (rst)
        req_valid && !walk_req && ctrl_en && leaf_sp && leaf_wr
        |=> dec_allow && !walk_req); // R3

    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (rst)
        walk_req && !walk_gnt |=> walk_req); // R4

    AST_WALK_DROP: assert property (@(posedge clk) disable iff (rst)
        walk_req && walk_gnt |=> !walk_req && (dec_allow || dec_viol || dec_fault)); // R6

    AST_MISS_PASS: assert property (@(posedge clk) disable iff (rst)
        walk_req && walk_gnt && walk_miss && !walk_misconf
        |=> dec_fault && dec_fault_miss); // R8

    AST_MISCONF_WINS: assert property (@(posedge clk) disable iff (rst)
        walk_req && walk_gnt && walk_misconf |=> dec_fault && !dec_fault_miss); // R8

    AST_RSV_BITS: assert property (@(posedge clk) disable iff (rst)
        walk_req && walk_gnt && !walk_miss && !walk_misconf && odd_set
        |=> dec_fault && !dec_fault_miss); // R7

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        walk_req && !walk_gnt |=> $stable(walk_page) && !dec_allow && !dec_viol && !dec_fault); // R10

endmodule

bind subpage_wr_guard subpage_wr_guard_chk #(
    .VEC_W  (VEC_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ctrl_en        (ctrl_en),
    .req_valid      (req_valid),
    .leaf_sp        (req_leaf[subpage_pkg::SP_BIT]),
    .leaf_wr        (req_leaf[subpage_pkg::WR_BIT]),
    .walk_req       (walk_req),
    .walk_page      (walk_page),
    .walk_gnt       (walk_gnt),
    .walk_vec       (walk_vec),
    .walk_miss      (walk_miss),
    .walk_misconf   (walk_misconf),
    .dec_allow      (dec_allow),
    .dec_viol       (dec_viol),
    .dec_fault      (dec_fault),
    .dec_fault_miss (dec_fault_miss)
);

// File: tb/tb_subpage_wr_guard.sv
`timescale 1ns/1ps
module tb_subpage_wr_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [47:0] req_addr = '0;
    logic [63:0] req_leaf = '0;
    logic        walk_req;
    logic [35:0] walk_page;
    logic        walk_gnt = 1'b0;
    logic [63:0] walk_vec = '0;
    logic        walk_miss = 1'b0;
    logic        walk_misconf = 1'b0;
    logic        dec_allow, dec_viol, dec_fault, dec_fault_miss;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    subpage_wr_guard dut (
        .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .req_valid(req_valid),
        .req_addr(req_addr), .req_leaf(req_leaf), .walk_req(walk_req),
        .walk_page(walk_page), .walk_gnt(walk_gnt), .walk_vec(walk_vec),
        .walk_miss(walk_miss), .walk_misconf(walk_misconf),
        .dec_allow(dec_allow), .dec_viol(dec_viol), .dec_fault(dec_fault),
        .dec_fault_miss(dec_fault_miss)
    );

    // behavioural reference model
    bit          m_busy = 0;
    int          m_idx = 0;
    logic [35:0] m_page = '0;
    bit e_allow = 0, e_viol = 0, e_fault = 0, e_miss = 0;

    always @(posedge clk) begin
        e_allow = 0; e_viol = 0; e_fault = 0; e_miss = 0;
        if (rst) begin
            m_busy = 0;
        end else if (m_busy) begin
            if (walk_gnt) begin
                bit odd;
                odd = 0;
                m_busy = 0;
                for (int k = 0; k < 32; k++) if (walk_vec[2*k+1]) odd = 1;
                if (walk_misconf)      e_fault = 1;
                else if (walk_miss)    begin e_fault = 1; e_miss = 1; end
                else if (odd)          e_fault = 1;
                else if (walk_vec[2*m_idx]) e_allow = 1;
                else                   e_viol = 1;
            end
        end else if (req_valid) begin
            if (!ctrl_en || !req_leaf[61]) begin
                e_allow = req_leaf[1]; e_viol = !req_leaf[1];
            end else if (req_leaf[1]) begin
                e_allow = 1;
            end else begin
                m_busy = 1;
                m_idx  = int'(req_addr[11:7]);
                m_page = req_addr[47:12];
            end
        end
    end

    always @(negedge clk) begin
        bit ok;
        ok = (dec_allow == e_allow) && (dec_viol == e_viol) && (dec_fault == e_fault)
             && (dec_fault_miss == e_miss) && (walk_req == m_busy)
             && (!m_busy || walk_page == m_page);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cyc %0d: got a%0b v%0b f%0b m%0b wr%0b pg%h exp a%0b v%0b f%0b m%0b wr%0b pg%h",
                     tag, cyc, dec_allow, dec_viol, dec_fault, dec_fault_miss, walk_req, walk_page,
                     e_allow, e_viol, e_fault, e_miss, m_busy, m_page);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: got cycle %0d exp completion", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [63:0] mk_vec(input logic [31:0] perm);
        logic [63:0] v;
        v = '0;
        for (int k = 0; k < 32; k++) v[2*k] = perm[k];
        return v;
    endfunction

    task automatic send(input bit en, input bit sp, input bit wr, input logic [47:0] a);
        ctrl_en   = en;
        req_addr  = a;
        req_leaf  = 64'h0000_1234_5678_9000;
        req_leaf[61] = sp;
        req_leaf[1]  = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic reply(input int dly, input logic [63:0] v, input bit ms, input bit mc);
        for (int d = 0; d < dly; d++) @(negedge clk);
        walk_gnt = 1'b1; walk_vec = v; walk_miss = ms; walk_misconf = mc;
        @(negedge clk);
        walk_gnt = 1'b0; walk_vec = '0; walk_miss = 1'b0; walk_misconf = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        tag = "R2";
        send(0, 1, 0, 48'h0000_0000_1080);
        send(0, 0, 1, 48'h0000_0000_2000);
        send(1, 0, 0, 48'h0000_0000_3000);
        send(1, 0, 1, 48'h0000_0000_4000);
        @(negedge clk);

        tag = "R3";
        send(1, 1, 1, 48'h0000_0000_5F80);
        send(1, 1, 1, 48'h0000_0000_6000);
        @(negedge clk);

        tag = "R4";
        send(1, 1, 0, 48'hABCD_EF01_2000);
        reply(0, mk_vec(32'h0000_0001), 0, 0);

        tag = "R5";
        send(1, 1, 0, 48'h0000_1111_3F80);
        reply(2, mk_vec(32'h8000_0000), 0, 0);
        send(1, 1, 0, 48'h0000_1111_3F80);
        reply(1, mk_vec(32'h7FFF_FFFF), 0, 0);
        send(1, 1, 0, 48'h0000_2222_4280);
        reply(0, mk_vec(32'h0000_0020), 0, 0);

        tag = "R6";
        send(1, 1, 0, 48'h0000_3333_5100);
        reply(3, mk_vec(32'hFFFF_FDFF), 0, 0);
        send(1, 1, 0, 48'h0000_3333_5100);
        reply(1, mk_vec(32'h0000_0200), 0, 0);

        tag = "R7";
        send(1, 1, 0, 48'h0000_4444_6000);
        reply(1, mk_vec(32'hFFFF_FFFF) | 64'h8000_0000_0000_0000, 0, 0);

        tag = "R8";
        send(1, 1, 0, 48'h0000_5555_7000);
        reply(1, mk_vec(32'hFFFF_FFFF), 1, 0);
        send(1, 1, 0, 48'h0000_5555_7000);
        reply(0, mk_vec(32'hFFFF_FFFF), 0, 1);
        send(1, 1, 0, 48'h0000_5555_7000);
        reply(2, mk_vec(32'hFFFF_FFFF), 1, 1);

        tag = "R10";
        send(1, 1, 0, 48'h0000_6666_8000);
        send(0, 0, 1, 48'h0000_7777_9000);
        send(1, 1, 0, 48'h0000_8888_A080);
        reply(1, mk_vec(32'h0000_0001), 0, 0);

        tag = "R9";
        send(0, 0, 1, 48'h0);
        send(1, 1, 1, 48'h0);
        send(0, 1, 0, 48'h0);
        send(1, 1, 0, 48'h0000_9999_0F80);
        reply(0, mk_vec(32'h8000_0000), 0, 0);
        repeat (3) @(negedge clk);

        tag = "R1";
        rst = 1'b1;
        send(1, 1, 0, 48'h0000_AAAA_0000);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule